// File: doc/BRIEF.md
# Supervisor-Bit Next-PC and Trap Control

This block chooses the address of the next instruction for a small 32-bit RISC core. The core keeps its privilege level in the top bit of the program counter. When that bit is 1 the core is in kernel mode, and when it is 0 the core is in user mode. Each cycle the block looks at the current PC and several other inputs: the jump-register operand, the branch adder result, the branch decision, a decoded instruction class, the illegal-opcode flag, an interrupt request and reset. From these it produces the next PC and a source code for that choice. It also produces the value to write back to the register file, the write enable and the write address.

The user/kernel boundary is enforced on the write path into the PC. A user-mode jump or branch cannot set the privilege bit. An ordinary increment cannot carry into it. Traps are the only way into kernel mode, and each trap sends the PC to one of three fixed kernel entry addresses. A trap also saves the address of the following instruction in a fixed exception-pointer register. Interrupts are refused while the core runs in kernel mode, so kernel code cannot be re-entered.

The outputs are combinational. An external PC register is expected to load `next_pc` on every rising clock edge. The clock is used only by the embedded checks.

Top module: `svpc_nextpc_ctrl`

## Requirements
- R1: While `rst_n` is 0, `next_pc` is 0x80000000, `pc_src` is 3'b101 and `rf_we` is 0, whatever the other inputs are.
- R2: `illegal_op` = 1 selects `next_pc` = 0x80000004 and `pc_src` = 3'b011. It also writes the current PC + 4 to register 30 (`rf_we` = 1, `rf_waddr` = 30, `xp_write` = 1). This happens in either privilege mode.
- R3: `irq` = 1 with `cur_pc[31]` = 0 selects `next_pc` = 0x80000008 and `pc_src` = 3'b100. It also writes the current PC + 4 to register 30.
- R4: When `cur_pc[31]` = 1, `irq` has no effect. All outputs are the same as with `irq` = 0.
- R5: `instr_class` = 2'b01 (register jump) selects `pc_src` = 3'b010. The new bit 31 is `cur_pc[31]` AND `jmp_target[31]`, and bits 30:2 are taken from `jmp_target`.
- R6: `instr_class` = 2'b10 with `br_taken` = 1 selects `pc_src` = 3'b001. The new bit 31 keeps `cur_pc[31]`, so it is forced to 0 in user mode. Bits 30:2 are taken from `br_target`.
- R7: For a jump, and for a branch whether taken or not, `rf_we` = 1, `rf_waddr` = `rd_field` and `link_val` = the full 32-bit `cur_pc` + 4 with no bit masked.
- R8: With no trap, jump or taken branch, `pc_src` = 3'b000. `next_pc` is `cur_pc` + 4 with bit 31 kept from `cur_pc`, so a carry never changes the mode. If the class is not jump or branch (2'b00 or 2'b11), `rf_we` = 0.
- R9: Priority is reset, then illegal opcode, then unmasked interrupt, then jump or branch, then sequential.
- R10: Bits 1:0 of `next_pc` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the embedded checks |
| rst_n | input | 1 | Active-low reset request, synchronous to the consuming PC register |
| cur_pc | input | 32 | Address of the current instruction; bit 31 is the mode |
| jmp_target | input | 32 | Register operand of a register-indirect jump |
| br_target | input | 32 | Branch adder result |
| br_taken | input | 1 | Branch condition is true |
| instr_class | input | 2 | 00 other, 01 jump, 10 branch, 11 other |
| illegal_op | input | 1 | Opcode is illegal or unimplemented (includes supervisor calls) |
| irq | input | 1 | Asynchronous interrupt request, already edge-reduced to one cycle |
| rd_field | input | 5 | Destination register field of the instruction |
| next_pc | output | 32 | Address to load into the PC |
| pc_src | output | 3 | Source of `next_pc` (encodings in R1 to R8) |
| link_val | output | 32 | Value written to the register file (current PC + 4) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| xp_write | output | 1 | The write goes to the exception-pointer register |

## Verification
The checks assume that inputs change only between rising edges. They also assume that `cur_pc` is word aligned when it is used to judge sequential and link values, and that `irq` is a single-cycle pulse, so sampling once per edge reflects what the PC register would load. The bench drives every input on the falling edge and reads outputs one nanosecond later. Every `cur_pc` value it uses is a multiple of four, with unaligned addresses used only as jump and branch targets to exercise R10. Mode corner cases covered include increments that carry into bit 31 and interrupts arriving during kernel code. Simultaneous requests are applied to confirm the R9 ordering.

// File: rtl/svpc_pkg.sv
// Shared encodings for the next-PC and trap control block.
// Assumes a single-issue core in which the PC register loads next_pc on every edge.
package svpc_pkg;

    // Source of the next PC; the illegal-opcode code 3'b011 is fixed by the control unit.
    typedef enum logic [2:0] {
        PCS_SEQ   = 3'b000,
        PCS_BR    = 3'b001,
        PCS_JMP   = 3'b010,
        PCS_ILLOP = 3'b011,
        PCS_IRQ   = 3'b100,
        PCS_RESET = 3'b101
    } pc_src_e;

    // Decoded instruction class as seen by the next-PC logic.
    typedef enum logic [1:0] {
        IC_OTHER  = 2'b00,
        IC_JUMP   = 2'b01,
        IC_BRANCH = 2'b10,
        IC_SPARE  = 2'b11
    } iclass_e;

endpackage

// File: rtl/svpc_trap_arbiter.sv
// Priority arbiter for the next-PC source.
// Order: reset, illegal opcode, interrupt (user mode only), jump/branch, sequential.
// Assumes irq is already reduced to a single-cycle pulse by the requester.
module svpc_trap_arbiter
    import svpc_pkg::*;
(
    input  logic    rst_n,
    input  logic    illegal_op,
    input  logic    irq,
    input  logic    kernel_mode,
    input  iclass_e iclass,
    input  logic    br_taken,
    output pc_src_e sel,
    output logic    trap
);

    logic irq_live;

    // An interrupt counts only when the core runs in user mode.
    assign irq_live = irq && !kernel_mode;

    // Pick the highest-priority source.
    always_comb begin
        if (!rst_n)                             sel = PCS_RESET;
        else if (illegal_op)                    sel = PCS_ILLOP;
        else if (irq_live)                      sel = PCS_IRQ;
        else if (iclass == IC_JUMP)             sel = PCS_JMP;
        else if (iclass == IC_BRANCH && br_taken) sel = PCS_BR;
        else                                    sel = PCS_SEQ;
    end

    // Flag the two trap sources that save the exception pointer.
    assign trap = (sel == PCS_ILLOP) || (sel == PCS_IRQ);

endmodule

// File: rtl/svpc_target_guard.sv
// Builds every candidate next PC with the privilege bit protected.
// Assumes MODE_BIT is the top address bit; ALIGN_BITS low bits are cleared.
module svpc_target_guard #(
    parameter int AW         = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] jmp_target,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] jmp_pc,
    output logic [AW-1:0] br_pc,
    output logic [AW-1:0] link_val
);

    localparam int MB = AW - 1;
    localparam int STEP = 1 << ALIGN_BITS;

    logic [AW-1:0] align_mask;
    logic [AW-1:0] inc_pc;

    // Alignment mask, chosen by whether any low bits are to be cleared.
    generate
        if (ALIGN_BITS == 0) begin : g_no_align
            assign align_mask = '1;
        end else begin : g_align
            assign align_mask = {{(AW-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
        end
    endgenerate

    // Address of the following instruction; also the unmasked link value.
    assign inc_pc   = cur_pc + AW'(STEP);
    assign link_val = inc_pc;

    // Sequential step: a carry into the mode bit is discarded.
    assign seq_pc = {cur_pc[MB], inc_pc[MB-1:0]} & align_mask;

    // Register jump: may leave kernel mode but never enter it.
    assign jmp_pc = {cur_pc[MB] & jmp_target[MB], jmp_target[MB-1:0]} & align_mask;

    // Branch: the mode bit always stays as it is.
    assign br_pc  = {cur_pc[MB], br_target[MB-1:0]} & align_mask;

endmodule

// File: rtl/svpc_wb_select.sv
// Chooses the register-file write for the current instruction.
// A trap overrides the destination field with the exception-pointer index.
module svpc_wb_select
    import svpc_pkg::*;
#(
    parameter int RA_W   = 5,
    parameter int XP_IDX = 30
) (
    input  logic            rst_n,
    input  iclass_e         iclass,
    input  logic            trap,
    input  logic [RA_W-1:0] rd_field,
    output logic            rf_we,
    output logic [RA_W-1:0] rf_waddr,
    output logic            xp_write
);

    logic links;

    // Jumps and branches always write their link register.
    assign links = (iclass == IC_JUMP) || (iclass == IC_BRANCH);

    // Write enable and address, with nothing written during reset.
    always_comb begin
        xp_write = rst_n && trap;
        rf_we    = rst_n && (trap || links);
        rf_waddr = trap ? RA_W'(XP_IDX) : rd_field;
    end

endmodule

// File: rtl/svpc_nextpc_ctrl.sv
// Next-PC and trap control for a core whose privilege bit is PC[AW-1].
// Outputs are combinational; an external PC register loads next_pc each edge.
// The clock only samples the embedded checks.
module svpc_nextpc_ctrl
    import svpc_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          RA_W       = 5,
    parameter int          XP_IDX     = 30,
    parameter int          ALIGN_BITS = 2,
    parameter logic [31:0] VEC_RESET  = 32'h8000_0000,
    parameter logic [31:0] VEC_ILLOP  = 32'h8000_0004,
    parameter logic [31:0] VEC_IRQ    = 32'h8000_0008
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cur_pc,
    input  logic [AW-1:0]   jmp_target,
    input  logic [AW-1:0]   br_target,
    input  logic            br_taken,
    input  logic [1:0]      instr_class,
    input  logic            illegal_op,
    input  logic            irq,
    input  logic [RA_W-1:0] rd_field,
    output logic [AW-1:0]   next_pc,
    output logic [2:0]      pc_src,
    output logic [AW-1:0]   link_val,
    output logic            rf_we,
    output logic [RA_W-1:0] rf_waddr,
    output logic            xp_write
);

    localparam int MB = AW - 1;

    iclass_e       iclass;
    pc_src_e       sel;
    logic          trap;
    logic [AW-1:0] seq_pc, jmp_pc, br_pc;

    // Cast the raw class field to the shared type.
    assign iclass = iclass_e'(instr_class);

    svpc_trap_arbiter u_arb (
        .rst_n       (rst_n),
        .illegal_op  (illegal_op),
        .irq         (irq),
        .kernel_mode (cur_pc[MB]),
        .iclass      (iclass),
        .br_taken    (br_taken),
        .sel         (sel),
        .trap        (trap)
    );

    svpc_target_guard #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) u_guard (
        .cur_pc     (cur_pc),
        .jmp_target (jmp_target),
        .br_target  (br_target),
        .seq_pc     (seq_pc),
        .jmp_pc     (jmp_pc),
        .br_pc      (br_pc),
        .link_val   (link_val)
    );

    svpc_wb_select #(.RA_W(RA_W), .XP_IDX(XP_IDX)) u_wb (
        .rst_n    (rst_n),
        .iclass   (iclass),
        .trap     (trap),
        .rd_field (rd_field),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .xp_write (xp_write)
    );

    // Steer the chosen candidate onto the PC write path.
    always_comb begin
        unique case (sel)
            PCS_RESET: next_pc = AW'(VEC_RESET);
            PCS_ILLOP: next_pc = AW'(VEC_ILLOP);
            PCS_IRQ:   next_pc = AW'(VEC_IRQ);
            PCS_JMP:   next_pc = jmp_pc;
            PCS_BR:    next_pc = br_pc;
            default:   next_pc = seq_pc;
        endcase
    end

    assign pc_src = sel;

    // ---------------- embedded checks ----------------

    // Reset always lands on the boot vector without a register write (R1).
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_vec_r1: assert (next_pc == AW'(VEC_RESET) && !rf_we);
        end
    end

    // A trap saves PC + 4 into the exception pointer (R2, R3).
    p_trap_saves_xp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == PCS_ILLOP || pc_src == PCS_IRQ) |->
            (rf_we && rf_waddr == RA_W'(XP_IDX) && link_val == cur_pc + AW'(1 << ALIGN_BITS)));

    // An interrupt is never taken while the core is in kernel mode (R4).
    p_kernel_masks_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_pc[MB] |-> (pc_src != PCS_IRQ));

    // A user-mode jump never sets the privilege bit (R5).
    p_jump_no_escalate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == PCS_JMP && !cur_pc[MB]) |-> !next_pc[MB]);

    // Branches and sequential steps keep the mode bit (R6, R8).
    p_mode_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == PCS_SEQ || pc_src == PCS_BR) |-> (next_pc[MB] == cur_pc[MB]));

    // An illegal opcode outranks every lower source (R9).
    p_illop_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (pc_src == PCS_ILLOP && next_pc == AW'(VEC_ILLOP)));

    // The new PC is always word aligned (R10).
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc[1:0] == 2'b00);

endmodule

// File: tb/svpc_nextpc_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module svpc_nextpc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cur_pc, jmp_target, br_target;
    logic        br_taken, illegal_op, irq;
    logic [1:0]  instr_class;
    logic [4:0]  rd_field;
    logic [31:0] next_pc, link_val;
    logic [2:0]  pc_src;
    logic        rf_we, xp_write;
    logic [4:0]  rf_waddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    svpc_nextpc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .jmp_target(jmp_target),
        .br_target(br_target), .br_taken(br_taken), .instr_class(instr_class),
        .illegal_op(illegal_op), .irq(irq), .rd_field(rd_field),
        .next_pc(next_pc), .pc_src(pc_src), .link_val(link_val),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .xp_write(xp_write)
    );

    // Drive one instruction's inputs on the falling edge, then settle.
    task automatic drive(input logic [31:0] pc, input logic [1:0] cls,
                         input logic [31:0] jt, input logic [31:0] bt, input logic tk,
                         input logic ill, input logic rq, input logic [4:0] rd);
        @(negedge clk);
        cur_pc = pc; instr_class = cls; jmp_target = jt; br_target = bt;
        br_taken = tk; illegal_op = ill; irq = rq; rd_field = rd;
        #1;
    endtask

    // Compare the visible outputs with expectations; one check per call.
    task automatic expect_out(input string req, input logic [31:0] e_pc,
                              input logic [2:0] e_src, input logic e_we,
                              input logic [4:0] e_wa, input logic [31:0] e_link);
        n_checks++;
        if (next_pc !== e_pc || pc_src !== e_src || rf_we !== e_we ||
            (e_we && (rf_waddr !== e_wa || link_val !== e_link))) begin
            n_fail++;
            $display("FAIL %s: got pc=%h src=%b we=%b wa=%0d link=%h, expected pc=%h src=%b we=%b wa=%0d link=%h",
                     req, next_pc, pc_src, rf_we, rf_waddr, link_val,
                     e_pc, e_src, e_we, e_wa, e_link);
        end
    endtask

    task automatic t_reset;  // R1, R9: reset beats every request
        rst_n = 1'b0;
        drive(32'h0040_0000, 2'b01, 32'h8000_1234, 0, 1'b1, 1'b1, 1'b1, 5'd9);
        expect_out("R1", 32'h8000_0000, 3'b101, 1'b0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_sequential;  // R8
        drive(32'h0040_0000, 2'b00, 0, 0, 1'b0, 1'b0, 1'b0, 5'd4);
        expect_out("R8", 32'h0040_0004, 3'b000, 1'b0, 0, 0);
        drive(32'h7FFF_FFFC, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, 5'd4);
        expect_out("R8", 32'h0000_0000, 3'b000, 1'b0, 0, 0);
        drive(32'h8000_0100, 2'b00, 0, 0, 1'b0, 1'b0, 1'b0, 5'd4);
        expect_out("R8", 32'h8000_0104, 3'b000, 1'b0, 0, 0);
    endtask

    task automatic t_jump;  // R5, R7, R10
        drive(32'h0040_0000, 2'b01, 32'h8000_1234, 0, 1'b0, 1'b0, 1'b0, 5'd5);
        expect_out("R5", 32'h0000_1234, 3'b010, 1'b1, 5'd5, 32'h0040_0004);
        drive(32'h8000_0200, 2'b01, 32'h0000_2040, 0, 1'b0, 1'b0, 1'b0, 5'd1);
        expect_out("R5", 32'h0000_2040, 3'b010, 1'b1, 5'd1, 32'h8000_0204);
        drive(32'h8000_0200, 2'b01, 32'h8000_0010, 0, 1'b0, 1'b0, 1'b0, 5'd2);
        expect_out("R7", 32'h8000_0010, 3'b010, 1'b1, 5'd2, 32'h8000_0204);
        drive(32'h0000_1000, 2'b01, 32'h0000_1237, 0, 1'b0, 1'b0, 1'b0, 5'd6);
        expect_out("R10", 32'h0000_1234, 3'b010, 1'b1, 5'd6, 32'h0000_1004);
    endtask

    task automatic t_branch;  // R6, R7, R10
        drive(32'h0000_0300, 2'b10, 0, 32'h8000_0400, 1'b1, 1'b0, 1'b0, 5'd8);
        expect_out("R6", 32'h0000_0400, 3'b001, 1'b1, 5'd8, 32'h0000_0304);
        drive(32'h8000_0300, 2'b10, 0, 32'h0000_0400, 1'b1, 1'b0, 1'b0, 5'd8);
        expect_out("R6", 32'h8000_0400, 3'b001, 1'b1, 5'd8, 32'h8000_0304);
        drive(32'h0000_1000, 2'b10, 0, 32'h0000_0400, 1'b0, 1'b0, 1'b0, 5'd11);
        expect_out("R7", 32'h0000_1004, 3'b000, 1'b1, 5'd11, 32'h0000_1004);
        drive(32'h0000_0300, 2'b10, 0, 32'h0000_0402, 1'b1, 1'b0, 1'b0, 5'd8);
        expect_out("R10", 32'h0000_0400, 3'b001, 1'b1, 5'd8, 32'h0000_0304);
    endtask

    task automatic t_illegal;  // R2, R9
        drive(32'h0000_2004, 2'b00, 0, 0, 1'b0, 1'b1, 1'b0, 5'd7);
        expect_out("R2", 32'h8000_0004, 3'b011, 1'b1, 5'd30, 32'h0000_2008);
        drive(32'h8000_0050, 2'b00, 0, 0, 1'b0, 1'b1, 1'b0, 5'd7);
        expect_out("R2", 32'h8000_0004, 3'b011, 1'b1, 5'd30, 32'h8000_0054);
        drive(32'h0000_3000, 2'b01, 32'h0000_0100, 0, 1'b0, 1'b1, 1'b1, 5'd3);
        expect_out("R9", 32'h8000_0004, 3'b011, 1'b1, 5'd30, 32'h0000_3004);
    endtask

    task automatic t_interrupt;  // R3, R4, R9
        drive(32'h0000_2040, 2'b01, 32'h0000_0100, 0, 1'b0, 1'b0, 1'b1, 5'd3);
        expect_out("R3", 32'h8000_0008, 3'b100, 1'b1, 5'd30, 32'h0000_2044);
        drive(32'h8000_0020, 2'b00, 0, 0, 1'b0, 1'b0, 1'b1, 5'd3);
        expect_out("R4", 32'h8000_0024, 3'b000, 1'b0, 0, 0);
        drive(32'h8000_0020, 2'b01, 32'h0000_0100, 0, 1'b0, 1'b0, 1'b1, 5'd3);
        expect_out("R4", 32'h0000_0100, 3'b010, 1'b1, 5'd3, 32'h8000_0024);
        n_checks++;
        if (xp_write !== 1'b0) begin
            n_fail++;
            $display("FAIL R4: xp_write=%b expected 0", xp_write);
        end
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cur_pc = 0; jmp_target = 0; br_target = 0;
        br_taken = 0; illegal_op = 0; irq = 0; instr_class = 0; rd_field = 0;
        t_reset();
        t_sequential();
        t_jump();
        t_branch();
        t_illegal();
        t_interrupt();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule